// File: doc/BRIEF.md
# Fractional Clock-Enable Divider with Committed Updates

This block divides an input clock by a divisor that may carry a fractional part and delivers the result as a stream of single-cycle clock-enable pulses. The divisor is programmed through an 8-bit field whose lowest 3 bits are fractional. The field holds the divisor minus one, and that one is counted at the weight of the lowest integer bit (value 8 in field units), so the scaled divisor is the field plus 8. A phase accumulator adds 8 on every enabled input cycle. It emits a pulse whenever the sum reaches the scaled divisor and then subtracts the divisor. The average pulse rate is therefore the input rate times 8 divided by the scaled divisor.

A new field value is staged in a pending register and does not take effect until it is committed. Software commits by writing a 1 to the trigger bit. The trigger then reads busy. The pending value replaces the active one at the next output-pulse boundary, where the accumulator restarts from zero, and the trigger reads idle one cycle later. All register writes are accepted only while the gate enable input is high. While the gate is low, the divider freezes and emits nothing.

Top module: `frac_clk_divider`

## Requirements
- R1: After synchronous reset, `tick` is 0, `trig_busy` is 0 and `cur_field` equals 8'h08, which means divide by 2.
- R2: With the gate enabled, the accumulator adds 8 each cycle. When the sum is at least (active field + 8), `tick` is 1 in the following cycle and the sum minus (field + 8) is kept. Otherwise `tick` is 0 and the sum is kept.
- R3: A write with `wr_sel`=0 loads `wr_data[7:0]` as the pending field. Bits [2:0] are fractional, so field 8'h04 gives exactly 2 pulses every 3 cycles.
- R4: A write to the pending field leaves `cur_field` and the pulse pattern unchanged until a commit occurs.
- R5: A write with `wr_sel`=1 and `wr_data[0]`=1 while the gate is enabled makes `trig_busy` read 1 from the next cycle.
- R6: While the trigger is busy, the first cycle that produces a pulse copies the pending field to `cur_field` and clears the accumulator. `trig_busy` returns to 0 one cycle after `cur_field` changes.
- R7: Writes to either register while `gate_en` is 0 are ignored. The trigger stays 0 and the pending field keeps its value.
- R8: While `gate_en` is 0, `tick` is 0 and the accumulator holds its value.
- R9: A trigger write with `wr_data[0]`=0, or a trigger write while already busy, does not change the trigger state.
- R10: A field with zero fractional bits, such as 8'h18, yields exactly one pulse every (field/8 + 1) cycles. The first pulse comes in the fourth cycle after a commit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock |
| rst | input | 1 | Synchronous active-high reset |
| gate_en | input | 1 | Clock gate enable; writes and counting only when high |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 selects the divider register, 1 the trigger register |
| wr_data | input | 32 | Write data; field in [7:0], trigger in [0] |
| tick | output | 1 | Clock-enable pulse output |
| trig_busy | output | 1 | Trigger read value; 1 while a commit is pending |
| cur_field | output | 8 | Field value currently applied to the divider |

## Verification
A corrupted accumulator becomes visible at `tick` within a single divisor period. Pulses arrive early or late against the reference pattern, and the rhythm stays shifted until the next commit restarts the phase. A wrong pending or active field shows up in `cur_field` on the cycle after the commit edge. A trigger state that sticks or clears too early appears in `trig_busy` one cycle after the commit. The bench therefore compares all three outputs against a reference model on every cycle, so any divergence is reported at the first cycle it reaches a port.

// File: rtl/fdiv_pkg.sv
package fdiv_pkg;

    localparam int FIELD_W = 8;
    localparam int FRAC_W  = 3;
    localparam int REG_W   = 32;
    localparam int ACC_W   = FIELD_W + 2;

    typedef logic [FIELD_W-1:0] field_t;
    typedef logic [ACC_W-1:0]   acc_t;

    localparam acc_t UNIT_STEP = acc_t'(1) << FRAC_W;

    typedef enum logic [1:0] {
        TRIG_IDLE,
        TRIG_ARMED,
        TRIG_APPLIED
    } trig_state_e;

    typedef struct packed {
        logic   en;
        logic   sel;
        field_t field;
        logic   go;
    } wr_req_t;

    // Scaled divisor: stored field plus one unit at the lowest integer weight.
    function automatic acc_t scaled_divisor(field_t f);
        return acc_t'(f) + UNIT_STEP;
    endfunction

endpackage

// File: rtl/fdiv_accum.sv
module fdiv_accum
    import fdiv_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   run,
    input  logic   restart,
    input  field_t div_field,
    output logic   boundary,
    output logic   tick
);

    acc_t acc_q;
    acc_t sum;
    acc_t divisor;

    always_comb begin
        divisor  = scaled_divisor(div_field);
        sum      = acc_q + UNIT_STEP;
        boundary = run && (sum >= divisor);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
            tick  <= 1'b0;
        end else begin
            tick <= boundary;
            if (run) begin
                if (restart)       acc_q <= '0;
                else if (boundary) acc_q <= sum - divisor;
                else               acc_q <= sum;
            end
        end
    end

    // R2: the kept phase always stays below the active divisor
    assert_acc_below_divisor_R2: assert property (@(posedge clk) disable iff (rst)
        acc_q < divisor);

    // R8: a stopped gate yields no pulse and freezes the phase
    assert_no_tick_gated_R8: assert property (@(posedge clk) disable iff (rst)
        !run |=> !tick);
    assert_phase_frozen_R8: assert property (@(posedge clk) disable iff (rst)
        !run |=> $stable(acc_q));

endmodule

// File: rtl/fdiv_ctrl.sv
module fdiv_ctrl
    import fdiv_pkg::*;
#(
    parameter field_t RESET_FIELD = field_t'(8)
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    gate_en,
    input  wr_req_t req,
    input  logic    boundary,
    output logic    commit,
    output logic    busy,
    output field_t  active_field
);

    field_t      pending_q;
    field_t      active_q;
    trig_state_e st_q;
    logic        accept;

    always_comb begin
        accept       = req.en && gate_en;
        commit       = (st_q == TRIG_ARMED) && boundary;
        busy         = (st_q != TRIG_IDLE);
        active_field = active_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pending_q <= RESET_FIELD;
            active_q  <= RESET_FIELD;
            st_q      <= TRIG_IDLE;
        end else begin
            if (accept && !req.sel)
                pending_q <= req.field;
            if (commit)
                active_q <= pending_q;
            unique case (st_q)
                TRIG_IDLE:    if (accept && req.sel && req.go) st_q <= TRIG_ARMED;
                TRIG_ARMED:   if (commit) st_q <= TRIG_APPLIED;
                TRIG_APPLIED: st_q <= TRIG_IDLE;
                default:      st_q <= TRIG_IDLE;
            endcase
        end
    end

    // R5: busy only starts after an accepted trigger write
    assert_busy_from_trigger_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(gate_en && req.en && req.sel && req.go));

    // R6: busy drops one cycle after the commit edge
    assert_busy_clears_after_commit_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> $past(commit, 2));

    // R4: the applied field moves only on a commit
    assert_field_moves_on_commit_R4: assert property (@(posedge clk) disable iff (rst)
        !$stable(active_q) |-> $past(commit));

    // R7: with the gate off an idle trigger stays idle
    assert_gated_trigger_ignored_R7: assert property (@(posedge clk) disable iff (rst)
        (!gate_en && !busy) |=> !busy);

endmodule

// File: rtl/frac_clk_divider.sv
module frac_clk_divider
    import fdiv_pkg::*;
#(
    parameter field_t RESET_FIELD = field_t'(8)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               gate_en,
    input  logic               wr_en,
    input  logic               wr_sel,
    input  logic [REG_W-1:0]   wr_data,
    output logic               tick,
    output logic               trig_busy,
    output logic [FIELD_W-1:0] cur_field
);

    wr_req_t req;
    logic    boundary;
    logic    commit;
    field_t  active_field;
    logic    unused_hi_bits;

    always_comb begin
        req.en    = wr_en;
        req.sel   = wr_sel;
        req.field = wr_data[FIELD_W-1:0];
        req.go    = wr_data[0];
    end

    assign unused_hi_bits = ^wr_data[REG_W-1:FIELD_W];

    fdiv_ctrl #(.RESET_FIELD(RESET_FIELD)) u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .gate_en      (gate_en),
        .req          (req),
        .boundary     (boundary),
        .commit       (commit),
        .busy         (trig_busy),
        .active_field (active_field)
    );

    fdiv_accum u_accum (
        .clk       (clk),
        .rst       (rst),
        .run       (gate_en),
        .restart   (commit),
        .div_field (active_field),
        .boundary  (boundary),
        .tick      (tick)
    );

    assign cur_field = active_field;

    // R6: every commit lands on a pulse boundary
    assert_commit_on_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        commit |=> tick);

endmodule

// File: tb/tb_frac_clk_divider.sv
module tb_frac_clk_divider;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        gate_en = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_sel = 1'b0;
    logic [31:0] wr_data = '0;
    logic        tick;
    logic        trig_busy;
    logic [7:0]  cur_field;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    // reference model state
    int   m_acc;
    int   m_active;
    int   m_pend;
    int   m_st;
    logic m_tick;

    always #2.5 clk = ~clk;

    frac_clk_divider dut (
        .clk(clk), .rst(rst), .gate_en(gate_en), .wr_en(wr_en),
        .wr_sel(wr_sel), .wr_data(wr_data), .tick(tick),
        .trig_busy(trig_busy), .cur_field(cur_field)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic model_update();
        int  d;
        int  s;
        bit  bnd;
        bit  cmt;
        bit  acc_w;
        if (rst) begin
            m_acc = 0; m_active = 8; m_pend = 8; m_st = 0; m_tick = 1'b0;
            return;
        end
        d     = m_active + 8;
        s     = m_acc + 8;
        bnd   = gate_en && (s >= d);
        cmt   = (m_st == 1) && bnd;
        acc_w = wr_en && gate_en;
        m_tick = bnd;
        if (gate_en) m_acc = cmt ? 0 : (bnd ? s - d : s);
        if (cmt) m_active = m_pend;
        if (acc_w && !wr_sel) m_pend = int'(wr_data[7:0]);
        if (m_st == 2) m_st = 0;
        else if (m_st == 1) begin
            if (cmt) m_st = 2;
        end else if (acc_w && wr_sel && wr_data[0]) m_st = 1;
    endtask

    task automatic step();
        @(posedge clk);
        model_update();
        @(negedge clk);
        check(tick == m_tick, "R2 tick", int'(tick), int'(m_tick));
        check(trig_busy == (m_st != 0), "R5 trig_busy", int'(trig_busy), int'(m_st != 0));
        check(int'(cur_field) == m_active, "R6 cur_field", int'(cur_field), m_active);
    endtask

    task automatic wr(input logic sel, input logic [31:0] data);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        step();
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic wait_idle();
        int guard = 0;
        while (trig_busy && guard < 2000) begin
            step();
            guard++;
        end
        check(!trig_busy, "R6 commit reached", int'(trig_busy), 0);
    endtask

    initial begin : watchdog
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                errors++;
                checks++;
                $display("FAIL watchdog expired actual %0d expected below 150000", cycles);
                $display("CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    initial begin : main
        int unsigned seed;
        int cnt;
        int first;
        seed = $urandom(32'h5EED);
        repeat (3) step();
        @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check(tick == 1'b0, "R1 tick", int'(tick), 0);
        check(trig_busy == 1'b0, "R1 trig_busy", int'(trig_busy), 0);
        check(cur_field == 8'h08, "R1 cur_field", int'(cur_field), 8);

        gate_en = 1'b1;
        repeat (5) step();

        // R3 fractional field 8'h04: 2 pulses every 3 cycles
        wr(1'b0, 32'hFFFF_FF04);
        wr(1'b1, 32'h1);
        check(trig_busy == 1'b1, "R5 busy after trigger", int'(trig_busy), 1);
        wait_idle();
        check(cur_field == 8'h04, "R3 field applied", int'(cur_field), 4);
        cnt = int'(tick);
        for (int i = 1; i < 30; i++) begin step(); cnt += int'(tick); end
        check(cnt == 20, "R3 fractional rate", cnt, 20);

        // R10 integer field 8'h18: divide by 4
        wr(1'b0, 32'h18);
        wr(1'b1, 32'h1);
        wait_idle();
        cnt = int'(tick);
        first = tick ? 1 : 0;
        for (int i = 2; i <= 40; i++) begin
            step();
            cnt += int'(tick);
            if (tick && first == 0) first = i;
        end
        check(cnt == 10, "R10 integer rate", cnt, 10);
        check(first == 4, "R10 first pulse", first, 4);

        // R4 staged write leaves the applied field alone
        wr(1'b0, 32'h04);
        repeat (12) step();
        check(cur_field == 8'h18, "R4 no change before commit", int'(cur_field), 8'h18);
        wr(1'b0, 32'h18);

        // R9 trigger write with bit 0 clear does nothing
        wr(1'b1, 32'hFFFF_FFFE);
        check(trig_busy == 1'b0, "R9 zero trigger ignored", int'(trig_busy), 0);

        // R8 gate off: no pulses
        gate_en = 1'b0;
        cnt = 0;
        for (int i = 0; i < 10; i++) begin step(); cnt += int'(tick); end
        check(cnt == 0, "R8 no pulses gated", cnt, 0);

        // R7 writes ignored while gated
        wr(1'b0, 32'h55);
        wr(1'b1, 32'h1);
        repeat (3) step();
        check(trig_busy == 1'b0, "R7 trigger ignored gated", int'(trig_busy), 0);
        gate_en = 1'b1;
        wr(1'b1, 32'h1);
        wr(1'b1, 32'h1);
        check(trig_busy == 1'b1, "R9 retrigger while busy", int'(trig_busy), 1);
        wait_idle();
        check(cur_field == 8'h18, "R7 pending kept", int'(cur_field), 8'h18);

        // constrained random traffic against the model
        for (int i = 0; i < 4000; i++) begin
            gate_en = ($urandom_range(99, 0) < 85);
            wr_en   = ($urandom_range(99, 0) < 15);
            wr_sel  = $urandom_range(1, 0) == 1;
            wr_data = $urandom;
            if (!wr_sel && $urandom_range(3, 0) == 0) wr_data[7:0] = 8'h00;
            step();
        end
        wr_en = 1'b0;
        gate_en = 1'b1;
        repeat (20) step();

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule